// File: doc/BRIEF.md
# Multi-channel PWM bank

A bank of independent pulse-width modulation channels that share one system clock and one synchronous register port. Each channel owns a control word and a duty word. The control word selects a two-stage clock divider, the pin drive style, the polarity, and the idle level. The duty word sets an 8-bit period length and the count values where the output turns on and off. A divided tick advances a per-channel counter. The counter runs from zero up to the period value and then wraps. The output is active while the count lies between the rising point and the falling point.

Software writes the duty word while a channel runs. By default the new values wait in a shadow copy and take effect at the next counter wrap, so no period is ever built from a mix of old and new settings. A per-channel bit removes this wait for callers who want changes applied at once. Each channel drives a pin value and an output enable, so a pad can be driven push-pull or as open-drain.

Top module: `pwm_bank`

## Requirements
- R1: Channel c has its control word at byte address c*0x10 and its duty word at c*0x10+0x4. Both read back what was written. Any other offset inside a channel's 16-byte window reads as zero, and a write to such an offset changes nothing.
- R2: Control word fields, as read back: integer divider in [7:0], power-of-two divider exponent in [11:8], pin enable at bit 12, open-drain at bit 13, invert at bit 14, idle level at bit 15, clock enable at bit 16, immediate-update at bit 17. Bits [31:18] read as zero.
- R3: Duty word fields: rising point in [7:0], falling point in [15:8], period in [31:24]. Bits [23:16] read as zero.
- R4: While running, the counter advances once every 2^exp × (div+1) system clocks. It counts 0, 1, …, period and then returns to 0. A control write restarts the divider phase.
- R5: The generated level is active while rising ≤ count < min(falling, period). A falling point above the period acts as the period, so the output is never active for a whole period.
- R6: With invert set, the pin carries the complement of the generated level.
- R7: A channel runs only when both clock enable and pin enable are set. Otherwise its divider and counter are held at 0 and the pin carries the idle level, XORed with invert.
- R8: The output enable is 0 while pin enable is clear. With pin enable set and open-drain clear, it is 1.
- R9: In open-drain mode, the output enable is 1 only while the pin value is 0.
- R10: With immediate-update clear, a duty write to a running channel takes effect at the first counter wrap after the write.
- R11: With immediate-update set, a duty write takes effect one cycle after the write commits.
- R12: Writes to one channel leave every other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regWe | input | 1 | Write strobe, sampled on the rising clock edge |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| pwmOut | output | NUM_CH | Pin value for each channel |
| pwmOe | output | NUM_CH | Output enable for each channel |

## Verification
The bench builds the bank with four channels. At that size every address bit selects either a channel or a register, and four channels can be configured side by side and watched at once while single writes hit one of them. It uses small divider settings, from a tick every clock up to a tick every six clocks, together with short periods. This keeps full wrap cycles, falling-point clamping, and the exact wrap that releases a shadowed duty write within a few dozen clocks. The duty write in the shadow test is timed to land just after a wrap, so an update applied too early changes the pin visibly.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  parameter int CNT_W  = 8;
  parameter int DIVL_W = 8;
  parameter int DIVH_W = 4;
  localparam int PRE_W = (1 << DIVH_W) - 1;

  // MSB first: bit 17 down to bit 0 at default widths
  typedef struct packed {
    logic              syncOff;
    logic              clkOn;
    logic              idleLvl;
    logic              invert;
    logic              odMode;
    logic              pinOn;
    logic [DIVH_W-1:0] divPow;
    logic [DIVL_W-1:0] divInt;
  } chanCtrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] fallPt;
    logic [CNT_W-1:0] risePt;
  } chanDuty_t;

  typedef struct packed {
    logic ctrlWr;
    logic dutyWr;
  } chanStb_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              regWe,
  output logic [31:0]       regRdata,
  output chanCtrl_t         ctrlQ [NUM_CH],
  output chanDuty_t         dutyQ [NUM_CH],
  output chanStb_t          stb   [NUM_CH]
);
  localparam int CH_W    = ADDR_W - 4;
  localparam int CTRL_W  = $bits(chanCtrl_t);
  localparam int PER_LSB = 32 - CNT_W;
  localparam int GAP_W   = PER_LSB - 2 * CNT_W;

  logic [CH_W-1:0] chanSel;
  logic [3:0]      offs;
  logic            selOk;
  logic            hitCtrl;
  logic            hitDuty;

  assign chanSel = regAddr[ADDR_W-1:4];
  assign offs    = regAddr[3:0];
  assign selOk   = (int'(chanSel) < NUM_CH);
  assign hitCtrl = selOk && (offs == 4'h0);
  assign hitDuty = selOk && (offs == 4'h4);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic selC;
    assign selC   = (int'(chanSel) == c);
    assign stb[c] = '{ctrlWr: regWe & hitCtrl & selC,
                      dutyWr: regWe & hitDuty & selC};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[c] <= '0;
        dutyQ[c] <= '0;
      end else begin
        if (stb[c].ctrlWr) ctrlQ[c] <= chanCtrl_t'(regWdata[CTRL_W-1:0]);
        if (stb[c].dutyWr) begin
          dutyQ[c] <= '{period: regWdata[31:PER_LSB],
                        fallPt: regWdata[2*CNT_W-1:CNT_W],
                        risePt: regWdata[CNT_W-1:0]};
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(chanSel) == c) begin
        if (offs == 4'h0) begin
          regRdata = {{(32-CTRL_W){1'b0}}, ctrlQ[c]};
        end else if (offs == 4'h4) begin
          regRdata = {dutyQ[c].period, {GAP_W{1'b0}},
                      dutyQ[c].fallPt, dutyQ[c].risePt};
        end
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCtrl_t        ctrl,
  input  chanDuty_t        duty,
  input  chanStb_t         stb,
  output logic             pinVal,
  output logic             pinOe,
  output logic [CNT_W-1:0] cntOut
);
  logic              run;
  logic [PRE_W-1:0]  hCnt;
  logic [PRE_W-1:0]  hMax;
  logic [DIVL_W-1:0] lCnt;
  logic              hTick;
  logic              lDone;
  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic              atEnd;
  logic              wrapEvt;
  chanDuty_t         act;
  logic              pend;
  logic              loadAct;
  logic [CNT_W-1:0]  effFall;
  logic              cmpOn;
  logic              rawLvl;

  assign run     = ctrl.clkOn & ctrl.pinOn;
  assign hMax    = ~({PRE_W{1'b1}} << ctrl.divPow);
  assign hTick   = (hCnt == hMax);
  assign lDone   = (lCnt == ctrl.divInt);
  assign tick    = run & hTick & lDone;
  assign atEnd   = (cnt >= act.period);
  assign wrapEvt = tick & atEnd;
  assign loadAct = !run | ctrl.syncOff | (wrapEvt & pend);

  // two-stage divider: power-of-two stage feeds the integer stage
  always_ff @(posedge clk) begin
    if (!rstN || !run || stb.ctrlWr) begin
      hCnt <= '0;
      lCnt <= '0;
    end else if (hTick) begin
      hCnt <= '0;
      lCnt <= lDone ? '0 : lCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= atEnd ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act  <= '0;
      pend <= 1'b0;
    end else begin
      if (loadAct) act <= duty;
      if (stb.dutyWr) pend <= 1'b1;
      else if (loadAct) pend <= 1'b0;
    end
  end

  assign effFall = (act.fallPt > act.period) ? act.period : act.fallPt;
  assign cmpOn   = (cnt >= act.risePt) && (cnt < effFall);
  assign rawLvl  = run ? cmpOn : ctrl.idleLvl;
  assign pinVal  = rawLvl ^ ctrl.invert;
  assign pinOe   = ctrl.pinOn & (~ctrl.odMode | ~pinVal);
  assign cntOut  = cnt;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              regWe,
  output logic [31:0]       regRdata,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);
  chanCtrl_t        ctrlQ [NUM_CH];
  chanDuty_t        dutyQ [NUM_CH];
  chanStb_t         stb   [NUM_CH];
  logic [CNT_W-1:0] cntQ  [NUM_CH];

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .ctrlQ(ctrlQ), .dutyQ(dutyQ), .stb(stb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk(clk), .rstN(rstN), .ctrl(ctrlQ[c]), .duty(dutyQ[c]), .stb(stb[c]),
      .pinVal(pwmOut[c]), .pinOe(pwmOe[c]), .cntOut(cntQ[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input chanCtrl_t         ctrlQ [NUM_CH],
  input logic [CNT_W-1:0]  cntQ  [NUM_CH],
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] pwmOe
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic runC;
    assign runC = ctrlQ[c].clkOn & ctrlQ[c].pinOn;

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
      runC |=> (cntQ[c] == '0 || cntQ[c] == $past(cntQ[c]) ||
                {1'b0, cntQ[c]} == {1'b0, $past(cntQ[c])} + 1'b1));

    assert_held_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
      !runC |=> cntQ[c] == '0);

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rstN)
      !runC |-> pwmOut[c] == (ctrlQ[c].idleLvl ^ ctrlQ[c].invert));

    assert_oe_needs_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
      pwmOe[c] |-> ctrlQ[c].pinOn);

    assert_od_low_only_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[c].odMode && pwmOe[c]) |-> !pwmOut[c]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .cntQ(cntQ),
  .pwmOut(pwmOut), .pwmOe(pwmOe)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  localparam int NCH = 4;
  localparam int AW  = 6;

  typedef struct {
    int    cyc;
    int    ch;
    bit    pin;
    bit    oe;
    string tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] regAddr;
  logic [31:0]   regWdata;
  logic          regWe;
  logic [31:0]   regRdata;
  logic [NCH-1:0] pwmOut;
  logic [NCH-1:0] pwmOe;

  int checks = 0;
  int errors = 0;
  int cycCnt = 0;
  bit done   = 0;
  expItem_t expQ[$];

  pwm_bank #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  // monitor: compares queued expectations once their cycle is reached
  always @(negedge clk) begin
    int i;
    i = 0;
    while (i < expQ.size()) begin
      if (expQ[i].cyc <= cycCnt) begin
        checks++;
        if (expQ[i].cyc < cycCnt || pwmOut[expQ[i].ch] !== expQ[i].pin ||
            pwmOe[expQ[i].ch] !== expQ[i].oe) begin
          errors++;
          $display("FAIL %s: cycle %0d ch%0d pin=%0b oe=%0b expected pin=%0b oe=%0b",
                   expQ[i].tag, cycCnt, expQ[i].ch, pwmOut[expQ[i].ch],
                   pwmOe[expQ[i].ch], expQ[i].pin, expQ[i].oe);
        end
        expQ.delete(i);
      end else begin
        i++;
      end
    end
  end

  function automatic bit waveLvl(int cnt, int per, int rise, int fall);
    int eff;
    eff = (fall > per) ? per : fall;
    return (cnt >= rise) && (cnt < eff);
  endfunction

  task automatic pushItem(int cyc, int ch, bit pin, bit oe, string tag);
    expItem_t it;
    it.cyc = cyc; it.ch = ch; it.pin = pin; it.oe = oe; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushRun(int ch, int w, int k0, int k1, int p, int per, int rise,
                         int fall, bit inv, bit od, string tag);
    for (int k = k0; k <= k1; k++) begin
      bit pv;
      pv = waveLvl((k / p) % (per + 1), per, rise, fall) ^ inv;
      pushItem(w + k, ch, pv, od ? !pv : 1'b1, tag);
    end
  endtask

  task automatic pushConst(int ch, int w, int k0, int k1, bit pin, bit oe, string tag);
    for (int k = k0; k <= k1; k++) pushItem(w + k, ch, pin, oe, tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic regWrite(int ch, int off, logic [31:0] data, output int wCyc);
    @(negedge clk);
    regAddr  = AW'(ch * 16 + off);
    regWdata = data;
    regWe    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
    wCyc  = cycCnt;
  endtask

  task automatic regCheck(int ch, int off, logic [31:0] expv, string tag);
    @(negedge clk);
    regAddr = AW'(ch * 16 + off);
    #1;
    checks++;
    if (regRdata !== expv) begin
      errors++;
      $display("FAIL %s: read ch%0d off 0x%0h got 0x%08h expected 0x%08h",
               tag, ch, off, regRdata, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w, w0, w1, d, kd, ke, tmp;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state: R7 idle level 0, R8 no output enable
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (pwmOut[c] !== 1'b0 || pwmOe[c] !== 1'b0) begin
        errors++;
        $display("FAIL R8: reset ch%0d pin=%0b oe=%0b expected pin=0 oe=0",
                 c, pwmOut[c], pwmOe[c]);
      end
    end
    regCheck(0, 0, 32'h0, "R1");
    regCheck(0, 4, 32'h0, "R1");

    // R1 R2 R3: field readback and unused offsets
    regWrite(2, 0, 32'hFFFF_FFFF, tmp);
    regWrite(2, 4, 32'hFFFF_FFFF, tmp);
    regWrite(2, 8, 32'h1234_5678, tmp);
    regWrite(2, 12, 32'h0, tmp);
    regCheck(2, 0, 32'h0003_FFFF, "R2");
    regCheck(2, 4, 32'hFF00_FFFF, "R3");
    regCheck(2, 8, 32'h0, "R1");
    regCheck(2, 12, 32'h0, "R1");
    regWrite(2, 0, 32'h0, tmp);
    regWrite(2, 4, 32'h0, tmp);
    regCheck(2, 0, 32'h0, "R1");

    // R4 R5: ch0 tick every clock, period 3, falling point 2; ch1 stays idle (R12)
    regWrite(0, 4, 32'h0300_0200, tmp);
    regWrite(0, 0, 32'h0001_1000, w0);
    pushRun(0, w0, 1, 12, 1, 3, 0, 2, 0, 0, "R5");
    pushConst(1, w0, 1, 12, 0, 0, "R12");
    drain();

    // R4: ch1 prescaler 2^1*(2+1)=6, period 2, falling point 1
    regWrite(1, 4, 32'h0200_0100, tmp);
    regWrite(1, 0, 32'h0001_1102, w);
    pushRun(1, w, 1, 40, 6, 2, 0, 1, 0, 0, "R4");
    drain();

    // R6 with nonzero rising point R5: ch2 period 4, rise 1, fall 3, inverted
    regWrite(2, 4, 32'h0400_0301, tmp);
    regWrite(2, 0, 32'h0001_5000, w);
    pushRun(2, w, 1, 15, 1, 4, 1, 3, 1, 0, "R6");
    drain();

    // R5 clamp: falling point 9 above period 3
    regWrite(3, 4, 32'h0300_0900, tmp);
    regWrite(3, 0, 32'h0001_1000, w);
    pushRun(3, w, 1, 12, 1, 3, 0, 9, 0, 0, "R5");
    drain();

    // R9 open-drain
    regWrite(3, 0, 32'h0, tmp);
    regWrite(3, 0, 32'h0001_3000, w);
    pushRun(3, w, 1, 12, 1, 3, 0, 9, 0, 1, "R9");
    drain();

    // R7 R8: stopped channel drives idle level
    regWrite(3, 0, 32'h0000_9000, w);
    pushConst(3, w, 1, 3, 1, 1, "R7");
    drain();
    regWrite(3, 0, 32'h0000_D000, w);
    pushConst(3, w, 1, 3, 0, 1, "R7");
    drain();
    regWrite(3, 0, 32'h0000_F000, w);
    pushConst(3, w, 1, 3, 0, 1, "R9");
    drain();
    regWrite(3, 0, 32'h0000_8000, w);
    pushConst(3, w, 1, 3, 1, 0, "R8");
    drain();

    // R10: shadowed duty write on ch0 lands just after a wrap
    while (((cycCnt - w0) % 4) != 2) @(negedge clk);
    regWrite(0, 4, 32'h0300_0100, d);
    kd = d - w0;
    ke = ((kd / 4) + 1) * 4;
    for (int k = kd + 1; k <= kd + 12; k++) begin
      pushItem(w0 + k, 0, waveLvl(k % 4, 3, 0, (k >= ke) ? 1 : 2), 1'b1, "R10");
    end
    drain();

    // R11: immediate update on ch1
    regWrite(1, 0, 32'h0, tmp);
    regWrite(1, 0, 32'h0003_1102, w1);
    regWrite(1, 4, 32'h0200_0200, d);
    pushRun(1, w1, d - w1 + 1, d - w1 + 30, 6, 2, 0, 2, 0, 0, "R11");
    drain();

    // R12: registers of other channels untouched
    regCheck(1, 4, 32'h0200_0200, "R12");
    regCheck(0, 0, 32'h0001_1000, "R12");
    regCheck(3, 4, 32'h0300_0900, "R12");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule